// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands the thread blocks of a launched grid to a small array of multithreaded compute cores. A launch descriptor gives the grid size in two dimensions, the number of threads in each block, the registers each thread needs and the shared memory bytes each block needs. The dispatcher keeps a ledger of the resources in use on every core. It walks the block indices in order and offers each whole block to one core whose remaining capacity still admits it.

An offer is a one-hot start request that carries the block's x and y index. The offer is held until the chosen core accepts it. Each core reports every finished block with a one-cycle completion pulse, and that pulse returns the block's slot, threads, registers and shared memory to the core's ledger, so that waiting blocks can be placed. When every block of the grid has completed, a one-cycle grid-done pulse is raised and a new launch can be taken. A launch whose single block could never fit on an empty core is refused with an error flag, so it never stalls.

Top module: `block_dispatcher`

## Requirements
- R1: A launch is taken only in a cycle where `busy` is low. After an accepted, valid launch, `busy` is high from the next cycle until the cycle in which `grid_done` is high, where `busy` is low again.
- R2: Block indices are issued x-fastest: (0,0), (1,0), … (gx-1,0), (0,1), … up to (gx-1,gy-1). Each index is issued exactly once.
- R3: At most one bit of `start_valid` is high. The first offer appears two cycles after the launch cycle. An offer keeps its core and its index until that core's `start_ready` is high. The cycle after an accepted offer carries no offer.
- R4: A core never holds more than 8 resident blocks.
- R5: The thread counts of the blocks resident on a core never sum to more than 768, so 256-thread blocks fit 3 per core, 128-thread blocks fit 6 and 768-thread blocks fit 1.
- R6: On each core, the resident blocks' register needs (threads × registers per thread) never sum to more than 8192, and their shared memory never sums to more than 16384 bytes.
- R7: A `block_done` pulse on a core frees exactly one block's slot, threads, registers and shared memory on that core. The freed capacity lets pending blocks be placed there.
- R8: `grid_done` is a one-cycle pulse in the cycle after the completion pulse that finishes the last block of the grid.
- R9: A launch with gx = 0, gy = 0, threads = 0, threads > 768, threads × registers per thread > 8192 or shared memory > 16384 is refused. `launch_err` is high from the next cycle until the next accepted launch, and `busy` stays low. A valid accepted launch clears `launch_err`.
- R10: A launch request made while `busy` is high is ignored. The running grid keeps its size and its resource needs.
- R11: The target core is the first core with enough capacity, searching in order and wrapping around, starting from the core just after the previously chosen one. After reset the search starts at core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request |
| launch_gx | input | GDIM_W | Grid width in blocks |
| launch_gy | input | GDIM_W | Grid height in blocks |
| launch_threads | input | THR_W | Threads per block |
| launch_regs | input | RPT_W | Registers per thread |
| launch_shmem | input | SHM_W | Shared memory bytes per block |
| busy | output | 1 | A grid is in progress |
| launch_err | output | 1 | Last launch refused |
| start_valid | output | NUM_CORES | One-hot block offer per core |
| start_ready | input | NUM_CORES | Core accepts the offered block |
| start_bx | output | GDIM_W | Offered block x index |
| start_by | output | GDIM_W | Offered block y index |
| block_done | input | NUM_CORES | One block finished on that core |
| grid_done | output | 1 | Pulse when the whole grid has completed |

## Verification
`busy` and `launch_err` follow a launch by one cycle. The first offer follows it by two cycles. After a handshake, the next offer comes no earlier than two cycles later. `grid_done` follows the final completion pulse by one cycle. A behavioural reference model steps on the same rising edge as the design, using the same inputs. Every output is compared against the model at the following falling edge, so each result is checked in exactly the cycle in which it is due. Emulated cores accept offers and return completions with set or varying lifetimes and varying readiness. At the end of each grid, the peak residency they saw is compared with the limit that R4, R5 or R6 predicts.

// File: rtl/bd_pkg.sv
package bd_pkg;
   typedef enum logic {BD_IDLE = 1'b0, BD_RUN = 1'b1} bd_state_e;
endpackage

// File: rtl/bd_core_ledger.sv
module bd_core_ledger #(
   parameter int MAX_BLK  = 8,
   parameter int MAX_THR  = 768,
   parameter int REG_FILE = 8192,
   parameter int SHMEM    = 16384,
   localparam int BLK_W = $clog2(MAX_BLK + 1),
   localparam int THR_W = $clog2(MAX_THR + 1),
   localparam int REG_W = $clog2(REG_FILE + 1),
   localparam int SHM_W = $clog2(SHMEM + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   input  logic [THR_W-1:0] req_thr,
   input  logic [REG_W-1:0] req_reg,
   input  logic [SHM_W-1:0] req_shm,
   output logic             fits,
   output logic             released,
   output logic [BLK_W-1:0] used_blk,
   output logic [THR_W-1:0] used_thr,
   output logic [REG_W-1:0] used_reg,
   output logic [SHM_W-1:0] used_shm
);
   logic blk_ok, thr_ok, reg_ok, shm_ok;

   assign released = give && (used_blk != '0);

   assign blk_ok = used_blk < BLK_W'(MAX_BLK);
   assign thr_ok = ({1'b0, used_thr} + {1'b0, req_thr}) <= (THR_W+1)'(MAX_THR);
   assign reg_ok = ({1'b0, used_reg} + {1'b0, req_reg}) <= (REG_W+1)'(REG_FILE);
   assign shm_ok = ({1'b0, used_shm} + {1'b0, req_shm}) <= (SHM_W+1)'(SHMEM);
   assign fits   = blk_ok && thr_ok && reg_ok && shm_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_blk <= '0;
         used_thr <= '0;
         used_reg <= '0;
         used_shm <= '0;
      end else begin
         case ({take, released})
            2'b10: begin
               used_blk <= used_blk + 1'b1;
               used_thr <= used_thr + req_thr;
               used_reg <= used_reg + req_reg;
               used_shm <= used_shm + req_shm;
            end
            2'b01: begin
               used_blk <= used_blk - 1'b1;
               used_thr <= used_thr - req_thr;
               used_reg <= used_reg - req_reg;
               used_shm <= used_shm - req_shm;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bd_rr_pick.sv
module bd_rr_pick #(
   parameter int N = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     fits,
   input  logic [IDX_W-1:0] last,
   output logic             valid,
   output logic [IDX_W-1:0] sel
);
   always_comb begin
      valid = 1'b0;
      sel   = last;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (int'(last) + k) % N;
         if (!valid && fits[idx]) begin
            valid = 1'b1;
            sel   = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/bd_grid_walker.sv
module bd_grid_walker #(
   parameter int GDIM_W = 8,
   localparam int CNT_W = 2 * GDIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [GDIM_W-1:0] gx,
   input  logic [GDIM_W-1:0] gy,
   input  logic              step,
   output logic [GDIM_W-1:0] bx,
   output logic [GDIM_W-1:0] by,
   output logic [CNT_W-1:0]  total,
   output logic              all_issued
);
   logic [GDIM_W-1:0] gx_q;
   logic [CNT_W-1:0]  issued;

   assign all_issued = (issued == total);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bx <= '0; by <= '0; gx_q <= '0; issued <= '0; total <= '0;
      end else if (load) begin
         bx     <= '0;
         by     <= '0;
         gx_q   <= gx;
         issued <= '0;
         total  <= CNT_W'(gx) * CNT_W'(gy);
      end else if (step) begin
         issued <= issued + 1'b1;
         if (bx == gx_q - 1'b1) begin
            bx <= '0;
            by <= by + 1'b1;
         end else begin
            bx <= bx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
   import bd_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int GDIM_W    = 8,
   parameter int RPT_W     = 8,
   parameter int MAX_BLK   = 8,
   parameter int MAX_THR   = 768,
   parameter int REG_FILE  = 8192,
   parameter int SHMEM     = 16384,
   localparam int THR_W = $clog2(MAX_THR + 1),
   localparam int SHM_W = $clog2(SHMEM + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_valid,
   input  logic [GDIM_W-1:0]    launch_gx,
   input  logic [GDIM_W-1:0]    launch_gy,
   input  logic [THR_W-1:0]     launch_threads,
   input  logic [RPT_W-1:0]     launch_regs,
   input  logic [SHM_W-1:0]     launch_shmem,
   output logic                 busy,
   output logic                 launch_err,
   output logic [NUM_CORES-1:0] start_valid,
   input  logic [NUM_CORES-1:0] start_ready,
   output logic [GDIM_W-1:0]    start_bx,
   output logic [GDIM_W-1:0]    start_by,
   input  logic [NUM_CORES-1:0] block_done,
   output logic                 grid_done
);
   localparam int BLK_W  = $clog2(MAX_BLK + 1);
   localparam int REG_W  = $clog2(REG_FILE + 1);
   localparam int IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int CNT_W  = 2 * GDIM_W;
   localparam int PROD_W = THR_W + RPT_W;
   localparam int NR_W   = $clog2(NUM_CORES + 1);

   if (NUM_CORES < 1 || MAX_BLK < 1 || MAX_THR < 1 || REG_FILE < 1 || SHMEM < 1 ||
       GDIM_W < 1 || RPT_W < 1) begin : g_bad_params
      $error("block_dispatcher: every size parameter must be positive");
   end

   bd_state_e state;
   logic              offer_v;
   logic [IDX_W-1:0]  offer_c, last_c, pick_c;
   logic              pick_v;
   logic [THR_W-1:0]  req_thr;
   logic [REG_W-1:0]  req_reg;
   logic [SHM_W-1:0]  req_shm;
   logic [CNT_W-1:0]  done_cnt, total;
   logic              all_issued, accept, bad, hs, fin;
   logic [PROD_W-1:0] prod;
   logic [NR_W-1:0]   n_rel;

   logic [NUM_CORES-1:0]            fits, released, take;
   logic [NUM_CORES-1:0][BLK_W-1:0] used_blk;
   logic [NUM_CORES-1:0][THR_W-1:0] used_thr;
   logic [NUM_CORES-1:0][REG_W-1:0] used_reg;
   logic [NUM_CORES-1:0][SHM_W-1:0] used_shm;

   assign busy   = (state == BD_RUN);
   assign accept = launch_valid && (state == BD_IDLE);
   assign prod   = PROD_W'(launch_threads) * PROD_W'(launch_regs);
   assign bad    = (launch_gx == '0) || (launch_gy == '0) || (launch_threads == '0) ||
                   (launch_threads > THR_W'(MAX_THR)) || (prod > PROD_W'(REG_FILE)) ||
                   (launch_shmem > SHM_W'(SHMEM));
   assign hs     = offer_v && start_ready[offer_c];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign start_valid[c] = offer_v && (offer_c == IDX_W'(c));
      assign take[c]        = hs && (offer_c == IDX_W'(c));
      bd_core_ledger #(
         .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR), .REG_FILE(REG_FILE), .SHMEM(SHMEM)
      ) u_ledger (
         .clk(clk), .rst_n(rst_n), .take(take[c]), .give(block_done[c]),
         .req_thr(req_thr), .req_reg(req_reg), .req_shm(req_shm),
         .fits(fits[c]), .released(released[c]),
         .used_blk(used_blk[c]), .used_thr(used_thr[c]),
         .used_reg(used_reg[c]), .used_shm(used_shm[c])
      );
   end

   bd_rr_pick #(.N(NUM_CORES)) u_pick (
      .fits(fits), .last(last_c), .valid(pick_v), .sel(pick_c)
   );

   bd_grid_walker #(.GDIM_W(GDIM_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(accept && !bad),
      .gx(launch_gx), .gy(launch_gy), .step(hs),
      .bx(start_bx), .by(start_by), .total(total), .all_issued(all_issued)
   );

   always_comb begin
      n_rel = '0;
      for (int c = 0; c < NUM_CORES; c++) n_rel = n_rel + NR_W'(released[c]);
   end

   assign fin = (state == BD_RUN) && (n_rel != '0) && ((done_cnt + CNT_W'(n_rel)) == total);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= BD_IDLE;
         offer_v    <= 1'b0;
         offer_c    <= '0;
         last_c     <= IDX_W'(NUM_CORES - 1);
         req_thr    <= '0;
         req_reg    <= '0;
         req_shm    <= '0;
         done_cnt   <= '0;
         launch_err <= 1'b0;
         grid_done  <= 1'b0;
      end else begin
         grid_done <= fin;
         if (accept) begin
            launch_err <= bad;
            if (!bad) begin
               state    <= BD_RUN;
               req_thr  <= launch_threads;
               req_reg  <= prod[REG_W-1:0];
               req_shm  <= launch_shmem;
               done_cnt <= '0;
            end
         end
         if (state == BD_RUN) begin
            done_cnt <= done_cnt + CNT_W'(n_rel);
            if (fin) state <= BD_IDLE;
         end
         if (hs) begin
            offer_v <= 1'b0;
         end else if ((state == BD_RUN) && !offer_v && !all_issued && pick_v) begin
            offer_v <= 1'b1;
            offer_c <= pick_c;
            last_c  <= pick_c;
         end
      end
   end
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
   parameter int NUM_CORES = 4,
   parameter int GDIM_W    = 8,
   parameter int MAX_BLK   = 8,
   parameter int MAX_THR   = 768,
   parameter int REG_FILE  = 8192,
   parameter int SHMEM     = 16384,
   localparam int BLK_W = $clog2(MAX_BLK + 1),
   localparam int THR_W = $clog2(MAX_THR + 1),
   localparam int REG_W = $clog2(REG_FILE + 1),
   localparam int SHM_W = $clog2(SHMEM + 1)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            busy,
   input logic                            launch_err,
   input logic                            grid_done,
   input logic [NUM_CORES-1:0]            start_valid,
   input logic [NUM_CORES-1:0]            start_ready,
   input logic [GDIM_W-1:0]               start_bx,
   input logic [GDIM_W-1:0]               start_by,
   input logic [NUM_CORES-1:0][BLK_W-1:0] used_blk,
   input logic [NUM_CORES-1:0][THR_W-1:0] used_thr,
   input logic [NUM_CORES-1:0][REG_W-1:0] used_reg,
   input logic [NUM_CORES-1:0][SHM_W-1:0] used_shm
);
   // R3
   offer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_valid));
   // R3
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_valid != '0) && ((start_valid & start_ready) == '0)) |=>
      ((start_valid == $past(start_valid)) && $stable(start_bx) && $stable(start_by)));
   // R3
   offer_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_valid & start_ready) != '0) |=> (start_valid == '0));
   // R1
   offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid != '0) |-> busy);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grid_done |-> !busy);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grid_done |=> !grid_done);
   // R9
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |-> !busy);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_lim
      // R4
      slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         used_blk[c] <= BLK_W'(MAX_BLK));
      // R5
      thread_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         used_thr[c] <= THR_W'(MAX_THR));
      // R6
      reg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         used_reg[c] <= REG_W'(REG_FILE));
      // R6
      shm_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         used_shm[c] <= SHM_W'(SHMEM));
   end
endmodule

bind block_dispatcher bd_checker #(
   .NUM_CORES(NUM_CORES), .GDIM_W(GDIM_W), .MAX_BLK(MAX_BLK),
   .MAX_THR(MAX_THR), .REG_FILE(REG_FILE), .SHMEM(SHMEM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .launch_err(launch_err),
   .grid_done(grid_done), .start_valid(start_valid), .start_ready(start_ready),
   .start_bx(start_bx), .start_by(start_by), .used_blk(used_blk),
   .used_thr(used_thr), .used_reg(used_reg), .used_shm(used_shm)
);

// File: tb/sim_block_dispatcher.sv
module sim_block_dispatcher;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4, GW = 8, RW = 8, THR_W = 10, SHM_W = 15;
   localparam int MAXB = 8, MAXT = 768, REGF = 8192, SHMB = 16384;

   logic clk = 1'b0, rst_n = 1'b0;
   logic launch_valid = 1'b0;
   logic [GW-1:0] launch_gx = '0, launch_gy = '0;
   logic [THR_W-1:0] launch_threads = '0;
   logic [RW-1:0] launch_regs = '0;
   logic [SHM_W-1:0] launch_shmem = '0;
   logic busy, launch_err, grid_done;
   logic [NC-1:0] start_valid, start_ready = '1, block_done = '0;
   logic [GW-1:0] start_bx, start_by;

   block_dispatcher u0 (
      .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_gx(launch_gx),
      .launch_gy(launch_gy), .launch_threads(launch_threads), .launch_regs(launch_regs),
      .launch_shmem(launch_shmem), .busy(busy), .launch_err(launch_err),
      .start_valid(start_valid), .start_ready(start_ready), .start_bx(start_bx),
      .start_by(start_by), .block_done(block_done), .grid_done(grid_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0, checks = 0;
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   int m_busy, m_err, m_done, m_ov, m_oc, m_bx, m_by, m_last, m_issued, m_total, m_compl;
   int m_gx, m_thr, m_reg, m_shm;
   int ub[NC], ut[NC], ur[NC], us[NC];
   // emulated cores
   int tmr[NC][MAXB], nres[NC], pend[NC];
   int peak0, life_len, rand_life, rand_ready, done_count;

   function automatic bit mfits(input int c);
      return ub[c] < MAXB && ut[c] + m_thr <= MAXT && ur[c] + m_reg <= REGF && us[c] + m_shm <= SHMB;
   endfunction

   always @(posedge clk) begin : model
      int ob, hs, oc, n, fin, gx, gy, th, rp, sh, found, dc;
      int rel[NC];
      if (!rst_n) begin
         m_busy = 0; m_err = 0; m_done = 0; m_ov = 0; m_oc = 0; m_last = NC - 1;
         m_bx = 0; m_by = 0; m_issued = 0; m_total = 0; m_compl = 0;
         m_gx = 0; m_thr = 0; m_reg = 0; m_shm = 0;
         for (int c = 0; c < NC; c++) begin
            ub[c] = 0; ut[c] = 0; ur[c] = 0; us[c] = 0; nres[c] = 0; pend[c] = 0;
         end
      end else begin
         ob = m_busy; oc = m_oc;
         hs = m_ov && start_ready[m_oc];
         n = 0;
         for (int c = 0; c < NC; c++) begin
            rel[c] = (block_done[c] && ub[c] > 0) ? 1 : 0;
            n += rel[c];
         end
         fin = (ob && n > 0 && m_compl + n == m_total) ? 1 : 0;
         if (hs) begin
            m_ov = 0; m_issued++;
            if (m_bx == m_gx - 1) begin m_bx = 0; m_by++; end else m_bx++;
         end else if (ob && !m_ov && m_issued < m_total) begin
            found = 0;
            for (int k = 1; k <= NC; k++) begin
               int i;
               i = (m_last + k) % NC;
               if (!found && mfits(i)) begin found = 1; m_ov = 1; m_oc = i; m_last = i; end
            end
         end
         for (int c = 0; c < NC; c++) begin
            if (hs && c == oc) begin ub[c]++; ut[c] += m_thr; ur[c] += m_reg; us[c] += m_shm; end
            if (rel[c] == 1) begin ub[c]--; ut[c] -= m_thr; ur[c] -= m_reg; us[c] -= m_shm; end
         end
         if (ob) m_compl += n;
         m_done = fin;
         if (fin) m_busy = 0;
         if (!ob && launch_valid) begin
            gx = int'(launch_gx); gy = int'(launch_gy); th = int'(launch_threads);
            rp = int'(launch_regs); sh = int'(launch_shmem);
            m_err = (gx == 0 || gy == 0 || th == 0 || th > MAXT || th * rp > REGF || sh > SHMB) ? 1 : 0;
            if (m_err == 0) begin
               m_busy = 1; m_gx = gx; m_thr = th; m_reg = th * rp; m_shm = sh;
               m_bx = 0; m_by = 0; m_issued = 0; m_compl = 0; m_total = gx * gy;
            end
         end
         // emulated cores, driven by the design's own handshake
         for (int c = 0; c < NC; c++) begin
            if (start_valid[c] && start_ready[c]) begin
               tmr[c][nres[c]] = rand_life ? 1 + int'($urandom % 20) : life_len;
               nres[c]++;
               if (c == 0 && nres[c] > peak0) peak0 = nres[c];
            end
            pend[c] = 0;
            for (int j = 0; j < nres[c]; j++) tmr[c][j]--;
            dc = -1;
            for (int j = 0; j < nres[c]; j++) if (dc < 0 && tmr[c][j] <= 0) dc = j;
            if (dc >= 0) begin
               for (int j = dc; j < nres[c] - 1; j++) tmr[c][j] = tmr[c][j+1];
               nres[c]--; pend[c] = 1; done_count++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy[0], "R1 busy", busy, m_busy);
         chk(launch_err == m_err[0], "R9 launch_err", launch_err, m_err);
         chk(start_valid == (m_ov ? NC'(1 << m_oc) : NC'(0)), "R3/R11 start_valid",
             start_valid, m_ov ? (1 << m_oc) : 0);
         if (m_ov) begin
            chk(start_bx == GW'(m_bx), "R2 start_bx", start_bx, m_bx);
            chk(start_by == GW'(m_by), "R2 start_by", start_by, m_by);
         end
         chk(grid_done == m_done[0], "R8 grid_done", grid_done, m_done);
      end
      for (int c = 0; c < NC; c++) begin
         block_done[c]  = pend[c][0];
         start_ready[c] = rand_ready ? ($urandom % 3 != 0) : 1'b1;
      end
   end

   task automatic do_launch(input int gx, input int gy, input int th, input int rp, input int sh);
      @(negedge clk);
      launch_valid = 1'b1; launch_gx = GW'(gx); launch_gy = GW'(gy);
      launch_threads = THR_W'(th); launch_regs = RW'(rp); launch_shmem = SHM_W'(sh);
      @(negedge clk);
      launch_valid = 1'b0;
   endtask

   task automatic run_grid(input int gx, input int gy, input int th, input int rp, input int sh,
                           input int exp_peak, input string tag);
      bit seen;
      peak0 = 0; done_count = 0; seen = 0;
      do_launch(gx, gy, th, rp, sh);
      for (int t = 0; t < 20000 && !seen; t++) begin
         @(negedge clk);
         if (grid_done) seen = 1;
      end
      chk(seen, "R8 grid finished", seen, 1);
      chk(done_count == gx * gy, "R7 completions equal block count", done_count, gx * gy);
      if (exp_peak > 0) chk(peak0 == exp_peak, tag, peak0, exp_peak);
   endtask

   task automatic bad_launch(input int gx, input int gy, input int th, input int rp, input int sh);
      do_launch(gx, gy, th, rp, sh);
      chk(launch_err == 1'b1, "R9 refused launch flags error", launch_err, 1);
      chk(busy == 1'b0, "R9 refused launch stays idle", busy, 0);
      repeat (2) @(negedge clk);
      chk(start_valid == '0, "R9 no offer after refusal", start_valid, 0);
   endtask

   initial begin
      rand_life = 0; rand_ready = 0; life_len = 5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && launch_err == 1'b0, "R1 reset idle", busy, 0);
      chk(start_valid == '0 && grid_done == 1'b0, "R3 reset no offer", start_valid, 0);
      // first offer timing and order on a small grid (R2, R3, R11)
      @(negedge clk);
      launch_valid = 1'b1; launch_gx = 8'd3; launch_gy = 8'd2;
      launch_threads = 10'd32; launch_regs = 8'd8; launch_shmem = '0;
      @(negedge clk);
      launch_valid = 1'b0;
      chk(busy == 1'b1 && start_valid == '0, "R3 no offer one cycle after launch", start_valid, 0);
      @(negedge clk);
      chk(start_valid == 4'b0001 && start_bx == '0 && start_by == '0,
          "R11 first offer to core 0 at index 0,0", start_valid, 1);
      while (busy) @(negedge clk);
      life_len = 400;
      run_grid(8, 5, 256, 4, 0, 3, "R5 peak of 256-thread blocks per core");
      run_grid(8, 5, 128, 4, 0, 6, "R5 peak of 128-thread blocks per core");
      run_grid(8, 5, 32, 8, 0, 8, "R4 peak resident blocks per core");
      run_grid(8, 5, 256, 16, 0, 2, "R6 peak limited by registers");
      run_grid(8, 5, 32, 1, 6000, 2, "R6 peak limited by shared memory");
      run_grid(2, 2, 768, 1, 0, 1, "R5 full-thread block alone on a core");
      life_len = 3;
      run_grid(8, 5, 256, 4, 0, 0, "");
      // varied readiness and lifetimes, plus a launch while busy (R10)
      rand_life = 1; rand_ready = 1; peak0 = 0; done_count = 0;
      do_launch(7, 3, 64, 4, 100);
      repeat (8) @(negedge clk);
      do_launch(1, 1, 32, 1, 0);
      chk(busy == 1'b1, "R10 launch while busy leaves grid running", busy, 1);
      while (busy) @(negedge clk);
      chk(done_count == 21, "R10 original grid size kept", done_count, 21);
      rand_life = 0; rand_ready = 0; life_len = 4;
      bad_launch(2, 2, 1000, 1, 0);
      bad_launch(2, 2, 256, 40, 0);
      bad_launch(2, 2, 32, 1, 17000);
      bad_launch(0, 2, 32, 1, 0);
      bad_launch(2, 2, 0, 1, 0);
      run_grid(3, 3, 64, 2, 0, 0, "");
      chk(launch_err == 1'b0, "R9 valid launch clears error", launch_err, 0);
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule